// File: doc/BRIEF.md
# Serial Byte FIFO Pair with Packed Status

This block holds the byte queues that sit between software and the bit engine of an asynchronous serial controller. Software pushes bytes into a transmit queue and pops bytes from a receive queue over a simple register bus. Each queue has its own control word with an enable, a self-clearing flush and an interrupt trigger level. One read-only status word packs the receive fill level, the transmit fill level and the transmit free space, so a driver can poll a single address before it writes.

On the line side, the transmit queue offers bytes to a serializer with a valid/ready handshake. The receive queue takes bytes from a deserializer the same way. When a received byte finds the queue full, the byte is lost and an overrun pulse is sent toward the controller's error state. Each direction raises a level interrupt request that is steered by its trigger level.

Register map (byte addresses): transmit control 0x00, receive control 0x04, status 0x08, transmit data 0x10, receive data 0x14. Read data is combinational in the cycle of the read strobe.

Top module: `serial_fifo_pair`

## Requirements
- R1: Status word (0x08) holds the receive fill in bits [5:0], the transmit fill in bits [13:8] and the transmit free space (capacity minus fill, 0 when transmit is disabled) in bits [29:24]. All other bits are 0.
- R2: Each control word (0x00 transmit, 0x04 receive) has enable at bit 0, flush at bit 1 and a 6-bit trigger level at bits [13:8]. It reads back the enable and the level, with the flush bit always reading 0.
- R3: A byte write to 0x10 pushes bus_wdata[7:0] into the transmit queue, which holds 16 bytes. A write while it holds 16 is dropped and the fill stays 16.
- R4: The transmit queue presents its oldest byte on tx_out_data with tx_out_valid high whenever it is not empty. The byte is removed on a cycle where valid and ready are both high, and order is preserved.
- R5: Each cycle where rx_in_valid and rx_in_ready are high stores one byte. A read of 0x14 returns the oldest byte in bits [7:0] and removes it. A read of an empty receive queue returns 0 and changes nothing.
- R6: A received byte that arrives while the receive queue holds 16 bytes is dropped, and rx_overrun is high in that same cycle. The bytes already stored are kept.
- R7: Writing a control word with the flush bit set empties that queue at the edge that takes the write. The flush may be combined with enable in one write.
- R8: While a direction is disabled, its fill reads 0, transmit free reads 0, transmit data writes are dropped, rx_in_ready is low and its interrupt request is low.
- R9: tx_irq is high while transmit is enabled and its fill is at or below the transmit trigger level.
- R10: rx_irq is high while receive is enabled and its fill is at or above the receive trigger level.
- R11: After reset both directions are disabled with levels 0, the status word reads 0, and tx_out_valid, tx_irq, rx_irq and rx_in_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| tx_out_valid | output | 1 | Transmit byte available to the serializer |
| tx_out_ready | input | 1 | Serializer takes the byte |
| tx_out_data | output | 8 | Oldest transmit byte |
| rx_in_valid | input | 1 | Deserializer offers a byte |
| rx_in_ready | output | 1 | Receive side is enabled |
| rx_in_data | input | 8 | Received byte |
| rx_overrun | output | 1 | Received byte lost because the queue is full |
| tx_irq | output | 1 | Transmit level interrupt request |
| rx_irq | output | 1 | Receive level interrupt request |

## Verification
A wrong occupancy count shows in the status word at the very next read and flips an interrupt request in the cycle after the faulty edge. A pointer error shows as a wrong or reordered byte on tx_out_data or in receive read data, at the first pop that reaches the bad slot. That can be up to 16 transfers later, so the bench fills and drains each queue completely. A flush or disable that fails to clear storage shows as a nonzero fill, or a nonzero free count, on the first status read after the control write.

// File: rtl/sfp_pkg.sv
// Shared register addresses and control-field positions for the serial FIFO pair.
// Assumes byte addressing with 32-bit register words.
package sfp_pkg;
    localparam logic [7:0] ADDR_TXCTL = 8'h00;
    localparam logic [7:0] ADDR_RXCTL = 8'h04;
    localparam logic [7:0] ADDR_STAT  = 8'h08;
    localparam logic [7:0] ADDR_TXDAT = 8'h10;
    localparam logic [7:0] ADDR_RXDAT = 8'h14;

    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_FLUSH_BIT = 1;
    localparam int CTL_LVL_LO    = 8;
    localparam int FIELD_W       = 6;

    localparam int STAT_RXFILL_LO = 0;
    localparam int STAT_TXFILL_LO = 8;
    localparam int STAT_TXFREE_LO = 24;
endpackage

// File: rtl/sfp_fifo.sv
// Synchronous FIFO with a clear input. Clear has priority over push and pop.
// A push to a full FIFO and a pop from an empty one are ignored.
// Assumes DEPTH >= 2; the read data is the oldest entry and is undefined when empty.
module sfp_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and occupancy update, cleared by reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= wdata;
    end
endmodule

// File: rtl/sfp_ctl_reg.sv
// One direction's control word: enable and trigger level are stored, flush is
// a strobe that never stores. The clear output asks the FIFO to empty on
// a flush write, on a write that disables, and for as long as it stays disabled.
module sfp_ctl_reg
    import sfp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [31:0]        wdata,
    output logic               en,
    output logic [FIELD_W-1:0] lvl,
    output logic               clr,
    output logic [31:0]        rdata
);
    // Stored enable and level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            lvl <= '0;
        end else if (wr) begin
            en  <= wdata[CTL_EN_BIT];
            lvl <= wdata[CTL_LVL_LO +: FIELD_W];
        end
    end

    assign clr = (wr && (wdata[CTL_FLUSH_BIT] || !wdata[CTL_EN_BIT])) || !en;

    // Read-back view with flush reading as 0.
    always_comb begin
        rdata = '0;
        rdata[CTL_EN_BIT] = en;
        rdata[CTL_LVL_LO +: FIELD_W] = lvl;
    end
endmodule

// File: rtl/serial_fifo_pair.sv
// Transmit and receive byte FIFOs for an asynchronous serial controller,
// with per-direction control words, a packed status word and level interrupts.
// Assumes single-cycle bus strobes and DEPTH <= 63 so counts fit the 6-bit fields.
module serial_fifo_pair
    import sfp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_out_valid,
    input  logic        tx_out_ready,
    output logic [7:0]  tx_out_data,
    input  logic        rx_in_valid,
    output logic        rx_in_ready,
    input  logic [7:0]  rx_in_data,
    output logic        rx_overrun,
    output logic        tx_irq,
    output logic        rx_irq
);
    logic               tx_en, rx_en, tx_clr, rx_clr;
    logic [FIELD_W-1:0] tx_lvl, rx_lvl;
    logic [31:0]        tx_ctl_rd, rx_ctl_rd;
    logic [CW-1:0]      tx_cnt, rx_cnt, tx_free;
    logic               tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]         rx_head;
    logic               tx_push, rx_push, rx_pop;
    logic [31:0]        status;

    sfp_ctl_reg u_txctl (
        .clk(clk), .rst_n(rst_n),
        .wr(bus_wr && bus_addr == ADDR_TXCTL), .wdata(bus_wdata),
        .en(tx_en), .lvl(tx_lvl), .clr(tx_clr), .rdata(tx_ctl_rd)
    );

    sfp_ctl_reg u_rxctl (
        .clk(clk), .rst_n(rst_n),
        .wr(bus_wr && bus_addr == ADDR_RXCTL), .wdata(bus_wdata),
        .en(rx_en), .lvl(rx_lvl), .clr(rx_clr), .rdata(rx_ctl_rd)
    );

    assign tx_push = bus_wr && bus_addr == ADDR_TXDAT && tx_en;
    assign rx_push = rx_in_valid && rx_en;
    assign rx_pop  = bus_rd && bus_addr == ADDR_RXDAT;

    sfp_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .pop(tx_out_valid && tx_out_ready),
        .wdata(bus_wdata[7:0]), .rdata(tx_out_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    sfp_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .pop(rx_pop),
        .wdata(rx_in_data), .rdata(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    assign tx_out_valid = !tx_empty;
    assign rx_in_ready  = rx_en;
    assign rx_overrun   = rx_push && rx_full;
    assign tx_free      = tx_en ? (CW'(DEPTH) - tx_cnt) : '0;
    assign tx_irq       = tx_en && (FIELD_W'(tx_cnt) <= tx_lvl);
    assign rx_irq       = rx_en && (FIELD_W'(rx_cnt) >= rx_lvl);

    // Packed status word: receive fill, transmit fill, transmit free.
    always_comb begin
        status = '0;
        status[STAT_RXFILL_LO +: FIELD_W] = FIELD_W'(rx_cnt);
        status[STAT_TXFILL_LO +: FIELD_W] = FIELD_W'(tx_cnt);
        status[STAT_TXFREE_LO +: FIELD_W] = FIELD_W'(tx_free);
    end

    // Read data multiplexer; an empty receive queue reads as 0.
    always_comb begin
        case (bus_addr)
            ADDR_TXCTL: bus_rdata = tx_ctl_rd;
            ADDR_RXCTL: bus_rdata = rx_ctl_rd;
            ADDR_STAT:  bus_rdata = status;
            ADDR_RXDAT: bus_rdata = rx_empty ? 32'h0 : {24'h0, rx_head};
            default:    bus_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/sfp_checker.sv
// Property checker for serial_fifo_pair, bound into every instance of it.
// Observes occupancy counts, clear requests and handshakes over time.
module sfp_checker
    import sfp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_en,
    input logic          rx_en,
    input logic          tx_clr,
    input logic          rx_clr,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic          tx_out_valid,
    input logic          tx_out_ready,
    input logic          rx_in_valid,
    input logic          rx_in_ready,
    input logic          rx_overrun,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [7:0]    bus_addr,
    input logic [31:0]   bus_wdata
);
    logic rx_acc;
    assign rx_acc = rx_in_valid && rx_in_ready && (rx_cnt != CW'(DEPTH));

    p_tx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == CW'(DEPTH) && !(tx_out_valid && tx_out_ready) && !tx_clr)
        |=> tx_cnt == CW'(DEPTH));

    p_rx_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_RXDAT && rx_cnt != '0 && !rx_acc && !rx_clr)
        |=> rx_cnt == $past(rx_cnt) - 1'b1);

    p_overrun_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> rx_cnt == CW'(DEPTH));

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_TXCTL && bus_wdata[CTL_FLUSH_BIT]) |=> tx_cnt == '0);

    p_disabled_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en |-> tx_cnt == '0) and (!rx_en |-> rx_cnt == '0));
endmodule

bind serial_fifo_pair sfp_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .tx_en(tx_en), .rx_en(rx_en), .tx_clr(tx_clr), .rx_clr(rx_clr),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_overrun(rx_overrun),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/sim_serial_fifo_pair.sv
`timescale 1ns/1ps
module sim_serial_fifo_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_out_valid, tx_out_ready = 1'b0;
    logic [7:0]  tx_out_data;
    logic        rx_in_valid = 1'b0, rx_in_ready;
    logic [7:0]  rx_in_data = '0;
    logic        rx_overrun, tx_irq, rx_irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rd_val;
    logic        ovr_seen;

    always #2 clk = ~clk;

    serial_fifo_pair u0 (.*);

    typedef struct packed {
        logic        is_rd;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] expv;
    } vec_t;

    // Register-level sequence: configure, push, flush, disable (R1 R2 R3 R7 R8).
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 32'h0000_0403, 32'h0},          // tx enable+flush, level 4
        '{1'b1, 8'h00, 32'h0,         32'h0000_0401},  // R2 flush reads 0
        '{1'b0, 8'h10, 32'h0000_00A1, 32'h0},
        '{1'b0, 8'h10, 32'h0000_00B2, 32'h0},
        '{1'b0, 8'h10, 32'h0000_00C3, 32'h0},
        '{1'b1, 8'h08, 32'h0,         32'h0D00_0300},  // R1 R3 fill 3, free 13
        '{1'b0, 8'h04, 32'h0000_0201, 32'h0},          // rx enable, level 2
        '{1'b1, 8'h04, 32'h0,         32'h0000_0201},  // R2
        '{1'b1, 8'h08, 32'h0,         32'h0D00_0300},  // R1
        '{1'b0, 8'h00, 32'h0000_0403, 32'h0},          // R7 flush with enable
        '{1'b1, 8'h08, 32'h0,         32'h1000_0000},  // R7
        '{1'b0, 8'h00, 32'h0000_0000, 32'h0},          // R8 disable tx
        '{1'b1, 8'h08, 32'h0,         32'h0000_0000},  // R8
        '{1'b0, 8'h10, 32'h0000_0055, 32'h0},          // R8 write while disabled
        '{1'b1, 8'h08, 32'h0,         32'h0000_0000},  // R8 dropped
        '{1'b0, 8'h00, 32'h0000_0401, 32'h0},          // re-enable, level 4
        '{1'b1, 8'h08, 32'h0,         32'h1000_0000}   // R8 nothing kept
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b, output logic ovr);
        @(negedge clk);
        rx_in_valid = 1'b1; rx_in_data = b;
        #1 ovr = rx_overrun;
        @(posedge clk); #1;
        rx_in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        reg_rd(8'h08, rd_val);
        check("R11 status", rd_val, 32'h0);
        check("R11 outputs", {28'h0, tx_out_valid, tx_irq, rx_irq, rx_in_ready}, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) begin
                reg_rd(VECS[i].addr, rd_val);
                check($sformatf("R1/R2/R3/R7/R8 vec %0d", i), rd_val, VECS[i].expv);
            end else begin
                reg_wr(VECS[i].addr, VECS[i].data);
            end
        end

        // R9 transmit level request
        check("R9 empty", {31'h0, tx_irq}, 32'h1);
        for (int i = 0; i < 4; i++) reg_wr(8'h10, 32'h10 + i);
        check("R9 fill at level", {31'h0, tx_irq}, 32'h1);
        reg_wr(8'h10, 32'h14);
        check("R9 fill above level", {31'h0, tx_irq}, 32'h0);
        for (int i = 5; i < 16; i++) reg_wr(8'h10, 32'h10 + i);
        reg_wr(8'h10, 32'hEE);
        reg_rd(8'h08, rd_val);
        check("R3 full drops write", rd_val, 32'h0000_1000);

        // R4 drain in order
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            tx_out_ready = 1'b1;
            #1 check("R4 byte", {23'h0, tx_out_valid, tx_out_data}, {23'h0, 1'b1, 8'(8'h10 + i)});
        end
        @(negedge clk);
        tx_out_ready = 1'b0;
        #1 check("R4 empty no valid", {31'h0, tx_out_valid}, 32'h0);

        // R10 receive level request and R5 read order
        rx_send(8'h31, ovr_seen);
        check("R6 no overrun", {31'h0, ovr_seen}, 32'h0);
        check("R10 below level", {31'h0, rx_irq}, 32'h0);
        rx_send(8'h32, ovr_seen);
        check("R10 at level", {31'h0, rx_irq}, 32'h1);
        reg_rd(8'h14, rd_val);
        check("R5 first", rd_val, 32'h31);
        reg_rd(8'h14, rd_val);
        check("R5 second", rd_val, 32'h32);
        reg_rd(8'h14, rd_val);
        check("R5 empty read", rd_val, 32'h0);
        reg_rd(8'h08, rd_val);
        check("R5 empty unchanged", rd_val, 32'h1000_0000);

        // R6 overrun on full receive queue
        for (int i = 0; i < 16; i++) rx_send(8'h40 + 8'(i), ovr_seen);
        reg_rd(8'h08, rd_val);
        check("R6 rx full", rd_val, 32'h1000_0010);
        rx_send(8'h99, ovr_seen);
        check("R6 overrun pulse", {31'h0, ovr_seen}, 32'h1);
        reg_rd(8'h08, rd_val);
        check("R6 fill kept", rd_val, 32'h1000_0010);
        reg_rd(8'h14, rd_val);
        check("R6 oldest kept", rd_val, 32'h40);

        // R7 receive flush with enable
        reg_wr(8'h04, 32'h0000_0203);
        reg_rd(8'h08, rd_val);
        check("R7 rx flush", rd_val, 32'h1000_0000);

        // R8 disabled directions
        reg_wr(8'h04, 32'h0);
        reg_wr(8'h00, 32'h0);
        check("R8 rx ready low", {31'h0, rx_in_ready}, 32'h0);
        check("R8 irqs low", {30'h0, tx_irq, rx_irq}, 32'h0);
        rx_send(8'h77, ovr_seen);
        reg_rd(8'h08, rd_val);
        check("R8 rx ignored", rd_val, 32'h0);

        finish_run();
    end
endmodule